// File: doc/BRIEF.md
# Debug Memory Access Engine

This block lets a debug host reach system memory one transfer at a time. The host sees three registers: a 32-bit control word, a transfer address and a data word. When the host writes the data word, the block issues one memory write. When the host requests a read of the data word, the block issues one memory read. Each transfer goes out on a simple two-phase, single-beat master port. The address phase is held until the slave is ready. The data phase completes when the slave signals ready, and an error response may come with it.

The control word selects the transfer size, the protection attributes, the security attribute and an auto-increment mode. It also holds two error policies: one stops further transfers after an error, the other keeps errors from being reported to the host. Four debug-enable inputs decide whether a transfer is allowed at all. Their live state also appears in two read-only bits of the control word. Register reads are combinational from the selected register. Every data-register access that is accepted ends with a single-cycle acknowledge, which may carry an error flag.

Top module: `dbgmem_ctl`

## Requirements
- R1: After reset the control word (select 0) reads 0x43000002 with all enable inputs low. Bit 6 reads dbgen OR niden and bit 23 reads spiden OR spniden, both following the live inputs.
- R2: Control bits 31, 29:28, 22:18, 15:8 and 3 always read 0, and writing them has no effect. Select 1 reads the address register, select 2 reads the data register and select 3 reads 0.
- R3: A control write whose size field [2:0] holds 3..7 leaves the size unchanged. A control write whose increment field [5:4] holds 2 or 3 leaves the increment mode unchanged. The other fields of the same write still take effect.
- R4: A data access starts a master transfer only when dbgen AND (spiden OR non-secure bit 30) holds. Otherwise the access is acknowledged one cycle later with the error flag set, and no address phase appears.
- R5: m_nonsec equals control bit 30. m_prot[3:0] equals control [27:24]. m_prot[4] and m_prot[6] copy control bit 27, and m_prot[5] is 0.
- R6: m_size equals the size field (0 = byte, 1 = halfword, 2 = word). A write transfer places the data word's low bytes on the byte lanes selected by address bits [1:0] and the size, and drives zeros on every other lane.
- R7: A successful read stores into the data register only the read-data byte lanes selected by address bits [1:0] and the size. All other lanes are stored as zero.
- R8: With increment field 1, a transfer that completes without an error response advances the address by 1, 2 or 4 bytes for size 0, 1 or 2. With increment field 0, after an error response, or after an abort, the address does not change.
- R9: An error response sets a sticky flag, and any host write to the control word clears it. While the flag is set and stop-on-error (bit 17) is 1, a data access is acknowledged with the error flag and starts no transfer. While bit 17 is 0, later transfers proceed normally.
- R10: With bit 16 set, an error response is acknowledged with the error flag low. With bit 16 clear, the error flag is high.
- R11: Bit 7 reads 1 from the cycle a transfer starts until its acknowledge. While bit 7 is 1, host writes to the control or address register and new data accesses are ignored. The address phase holds m_trans, m_addr and m_write steady until m_ready.
- R12: abort_req during an address phase that m_ready has not accepted drops the transfer. The drop is acknowledged with the error flag the next cycle, and the address is left unchanged.
- R13: host_ack is a one-cycle pulse per finished data access, and host_err is high only together with host_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Content of the selected register |
| host_ack | output | 1 | Data access finished |
| host_err | output | 1 | Data access failed (valid with host_ack) |
| dbgen | input | 1 | Invasive debug enable |
| niden | input | 1 | Non-invasive debug enable |
| spiden | input | 1 | Secure invasive debug enable |
| spniden | input | 1 | Secure non-invasive debug enable |
| abort_req | input | 1 | Drop a pending address phase |
| m_trans | output | 1 | Address phase active |
| m_addr | output | ADDR_W | Transfer address |
| m_write | output | 1 | Transfer direction, 1 = write |
| m_size | output | 3 | Transfer size code |
| m_prot | output | 7 | Protection attributes |
| m_nonsec | output | 1 | Non-secure attribute |
| m_wdata | output | 32 | Write data, lane aligned |
| m_ready | input | 1 | Slave ready |
| m_rdata | input | 32 | Slave read data |
| m_resp | input | 1 | Slave error response |

## Verification
The bench builds the block with ADDR_W = 32. Its slave model decodes sixteen words and answers with an error whenever address bit 8 is set, so every size and lane offset, with and without increment, can be swept against both good and failing addresses. The slave's wait states and address-phase stall are set by the bench. This puts the busy window, host writes ignored during it, and the address-phase abort within reach. All sixteen protection codes are crossed with both security settings.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  localparam logic [31:0] CTRL_RESET = 32'h4300_0002;

  // Legal size codes are 0..2, legal increment codes are 0..1.
  function automatic logic size_legal(input logic [2:0] sz);
    return sz <= 3'd2;
  endfunction

  function automatic logic inc_legal(input logic [1:0] inc);
    return inc <= 2'd1;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [2:0] sz);
    case (sz)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [2:0] sz, input logic [1:0] off);
    case (sz)
      3'd0:    return 32'h0000_00FF << {off, 3'b000};
      3'd1:    return 32'h0000_FFFF << {off[1], 4'b0000};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] place_lanes(input logic [31:0] d, input logic [2:0] sz,
                                              input logic [1:0] off);
    case (sz)
      3'd0:    return {24'h0, d[7:0]} << {off, 3'b000};
      3'd1:    return {16'h0, d[15:0]} << {off[1], 4'b0000};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dmac_ctrl_reg.sv
module dmac_ctrl_reg
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        nonsec,
  output logic [3:0]  prot,
  output logic        stop_on_err,
  output logic        no_pass,
  output logic [1:0]  inc_mode,
  output logic [2:0]  size
);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[31], wdata[29:28], wdata[23:18], wdata[15:6], wdata[3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nonsec      <= CTRL_RESET[30];
      prot        <= CTRL_RESET[27:24];
      stop_on_err <= CTRL_RESET[17];
      no_pass     <= CTRL_RESET[16];
      inc_mode    <= CTRL_RESET[5:4];
      size        <= CTRL_RESET[2:0];
    end else if (wr_en) begin
      nonsec      <= wdata[30];
      prot        <= wdata[27:24];
      stop_on_err <= wdata[17];
      no_pass     <= wdata[16];
      if (inc_legal(wdata[5:4])) inc_mode <= wdata[5:4];
      if (size_legal(wdata[2:0])) size <= wdata[2:0];
    end
  end

endmodule

// File: rtl/dmac_gate.sv
module dmac_gate (
  input  logic dbgen,
  input  logic niden,
  input  logic spiden,
  input  logic spniden,
  input  logic nonsec,
  output logic dev_en,
  output logic sdev_en,
  output logic xfer_ok
);

  assign dev_en  = dbgen | niden;
  assign sdev_en = spiden | spniden;
  assign xfer_ok = dbgen & (spiden | nonsec);

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [31:0]       wdata,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              ctrl_wr,
  input  logic              xfer_ok,
  input  logic              stop_on_err,
  input  logic              no_pass,
  input  logic [1:0]        inc_mode,
  input  logic [2:0]        size,
  input  logic              abort_req,
  input  logic              m_ready,
  input  logic [31:0]       m_rdata,
  input  logic              m_resp,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_q,
  output logic [31:0]       data_q,
  output logic              m_trans,
  output logic              m_write,
  output logic [31:0]       m_wdata,
  output logic              host_ack,
  output logic              host_err,
  output logic              inc_evt,
  output logic              stop_block
);

  seq_state_e state;
  logic       wr_q;
  logic       sticky;
  logic       start, deny, launch, accept, done, abort_evt;

  assign start      = start_rd | start_wr;
  assign stop_block = sticky & stop_on_err;
  assign deny       = start & (stop_block | ~xfer_ok);
  assign launch     = start & ~deny;
  assign accept     = (state == ST_ADDR) & m_ready;
  assign abort_evt  = (state == ST_ADDR) & ~m_ready & abort_req;
  assign done       = (state == ST_DATA) & m_ready;
  assign inc_evt    = done & ~m_resp & (inc_mode == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wr_q     <= 1'b0;
      sticky   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      host_ack <= 1'b0;
      host_err <= 1'b0;
    end else begin
      host_ack <= deny | done | abort_evt;
      host_err <= deny | abort_evt | (done & m_resp & ~no_pass);
      case (state)
        ST_IDLE: if (launch) state <= ST_ADDR;
        ST_ADDR: if (accept) state <= ST_DATA;
                 else if (abort_evt) state <= ST_IDLE;
        ST_DATA: if (done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (start) wr_q <= start_wr;
      if (start_wr) data_q <= wdata;
      else if (done & ~m_resp & ~wr_q) data_q <= m_rdata & lane_mask(size, addr_q[1:0]);
      if (addr_wr) addr_q <= addr_wdata;
      else if (inc_evt) addr_q <= addr_q + ADDR_W'(size_bytes(size));
      if (done & m_resp) sticky <= 1'b1;
      else if (ctrl_wr) sticky <= 1'b0;
    end
  end

  assign busy    = state != ST_IDLE;
  assign m_trans = state == ST_ADDR;
  assign m_write = busy & wr_q;
  assign m_wdata = (busy & wr_q) ? place_lanes(data_q, size, addr_q[1:0]) : 32'h0;

endmodule

// File: rtl/dbgmem_ctl.sv
module dbgmem_ctl
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_ack,
  output logic              host_err,
  input  logic              dbgen,
  input  logic              niden,
  input  logic              spiden,
  input  logic              spniden,
  input  logic              abort_req,
  output logic              m_trans,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_write,
  output logic [2:0]        m_size,
  output logic [6:0]        m_prot,
  output logic              m_nonsec,
  output logic [31:0]       m_wdata,
  input  logic              m_ready,
  input  logic [31:0]       m_rdata,
  input  logic              m_resp
);

  logic              nonsec, stop_on_err, no_pass;
  logic [3:0]        prot;
  logic [1:0]        inc_mode;
  logic [2:0]        size;
  logic              dev_en, sdev_en, xfer_ok;
  logic              busy, inc_evt, stop_block;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q, ctrl_view;
  logic              free_req, ctrl_wr, addr_wr, start_wr, start_rd;

  assign free_req = host_req & ~busy;
  assign ctrl_wr  = free_req & host_wr & (host_sel == SEL_CTRL);
  assign addr_wr  = free_req & host_wr & (host_sel == SEL_ADDR);
  assign start_wr = free_req & host_wr & (host_sel == SEL_DATA);
  assign start_rd = free_req & ~host_wr & (host_sel == SEL_DATA);

  dmac_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(host_wdata),
    .nonsec(nonsec), .prot(prot), .stop_on_err(stop_on_err), .no_pass(no_pass),
    .inc_mode(inc_mode), .size(size)
  );

  dmac_gate u_gate (
    .dbgen(dbgen), .niden(niden), .spiden(spiden), .spniden(spniden), .nonsec(nonsec),
    .dev_en(dev_en), .sdev_en(sdev_en), .xfer_ok(xfer_ok)
  );

  dmac_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr), .wdata(host_wdata),
    .addr_wr(addr_wr), .addr_wdata(host_wdata[ADDR_W-1:0]), .ctrl_wr(ctrl_wr),
    .xfer_ok(xfer_ok), .stop_on_err(stop_on_err), .no_pass(no_pass), .inc_mode(inc_mode),
    .size(size), .abort_req(abort_req), .m_ready(m_ready), .m_rdata(m_rdata), .m_resp(m_resp),
    .busy(busy), .addr_q(addr_q), .data_q(data_q), .m_trans(m_trans), .m_write(m_write),
    .m_wdata(m_wdata), .host_ack(host_ack), .host_err(host_err), .inc_evt(inc_evt),
    .stop_block(stop_block)
  );

  assign ctrl_view = {1'b0, nonsec, 2'b00, prot, sdev_en, 5'b0, stop_on_err, no_pass,
                      8'h00, busy, dev_en, inc_mode, 1'b0, size};

  always_comb begin
    case (host_sel)
      SEL_CTRL: host_rdata = ctrl_view;
      SEL_ADDR: host_rdata = 32'(addr_q);
      SEL_DATA: host_rdata = data_q;
      default:  host_rdata = 32'h0;
    endcase
  end

  assign m_addr   = addr_q;
  assign m_size   = size;
  assign m_prot   = {prot[3], 1'b0, prot[3], prot};
  assign m_nonsec = nonsec;

endmodule

// File: rtl/dmac_checks.sv
module dmac_checks #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ack,
  input logic              host_err,
  input logic              m_trans,
  input logic              m_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic              m_write,
  input logic [2:0]        m_size,
  input logic              m_nonsec,
  input logic              dbgen,
  input logic              spiden,
  input logic              abort_req,
  input logic              busy,
  input logic              stop_block,
  input logic              inc_evt
);

  // R13: the error flag never appears without an acknowledge
  a_r13_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> host_ack);

  // R4: a new address phase follows only an authorised start
  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_trans) |-> $past(dbgen && (spiden || m_nonsec)));

  // R9: an idle engine with a blocking error starts nothing
  a_r9_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_block && !busy) |=> !m_trans);

  // R8: an increment moves the address by the transfer width
  a_r8_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> (m_addr == $past(m_addr) + (ADDR_W'(1) << $past(m_size))));

  // R11: a stalled address phase keeps its request steady
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_trans && !m_ready && !abort_req) |=> (m_trans && $stable(m_addr) && $stable(m_write)));

  // R11: an address phase always counts as busy
  a_r11_trans_busy: assert property (@(posedge clk) disable iff (!rst_n)
    m_trans |-> busy);

endmodule

bind dbgmem_ctl dmac_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .host_ack(host_ack), .host_err(host_err), .m_trans(m_trans),
  .m_ready(m_ready), .m_addr(m_addr), .m_write(m_write), .m_size(m_size), .m_nonsec(m_nonsec),
  .dbgen(dbgen), .spiden(spiden), .abort_req(abort_req), .busy(busy),
  .stop_block(stop_block), .inc_evt(inc_evt)
);

// File: tb/dbgmem_ctl_test.sv
`timescale 1ns/1ps
module dbgmem_ctl_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_ack, host_err;
  logic dbgen = 0, niden = 0, spiden = 0, spniden = 0, abort_req = 0;
  logic m_trans, m_write, m_nonsec, m_ready, m_resp;
  logic [AW-1:0] m_addr;
  logic [2:0] m_size;
  logic [6:0] m_prot;
  logic [31:0] m_wdata, m_rdata;

  always #2 clk = ~clk;

  dbgmem_ctl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack), .host_err(host_err),
    .dbgen(dbgen), .niden(niden), .spiden(spiden), .spniden(spniden), .abort_req(abort_req),
    .m_trans(m_trans), .m_addr(m_addr), .m_write(m_write), .m_size(m_size), .m_prot(m_prot),
    .m_nonsec(m_nonsec), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .m_resp(m_resp)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- slave model ----
  function automatic logic [31:0] pattern(input logic [3:0] idx);
    return 32'hA55A_3CC3 ^ ({28'h0, idx} * 32'h0101_0101);
  endfunction

  logic dph = 0, stall_addr = 0;
  int wcnt = 0, waits = 0, ntrans = 0;
  logic [31:0] s_addr = '0, cap_wdata = '0;
  logic [2:0] s_sz = '0;

  assign m_ready = dph ? (wcnt == 0) : !stall_addr;
  assign m_resp  = dph & s_addr[8];
  assign m_rdata = dph ? pattern(s_addr[5:2]) : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) dph <= 1'b0;
    else if (dph) begin
      if (wcnt == 0) begin dph <= 1'b0; cap_wdata <= m_wdata; end
      else wcnt <= wcnt - 1;
    end else if (m_trans && m_ready) begin
      dph <= 1'b1; wcnt <= waits; s_addr <= m_addr; s_sz <= m_size; ntrans <= ntrans + 1;
    end
  end

  // ---- expected-value helpers ----
  function automatic logic [31:0] exp_mask(input int sz, input int off);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (b >= off && b < off + (1 << sz)) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] exp_place(input logic [31:0] d, input int sz, input int off);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) if (b >= off && b < off + (1 << sz)) r[8*b +: 8] = d[8*(b-off) +: 8];
    return r;
  endfunction

  // ---- host tasks ----
  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); host_req = 1; host_wr = 1; host_sel = sel; host_wdata = d;
    @(posedge clk); #1; host_req = 0; host_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); host_sel = sel; #1; d = host_rdata;
  endtask

  task automatic kick(input logic wr, input logic [31:0] d);
    @(negedge clk); host_req = 1; host_wr = wr; host_sel = 2'd2; host_wdata = d;
    @(posedge clk); #1; host_req = 0; host_wr = 0;
  endtask

  task automatic wait_ack(output logic acked, output logic err, output logic [31:0] rd);
    acked = 0; err = 0; rd = '0;
    for (int i = 0; i < 200; i++) begin
      if (host_ack) begin acked = 1; err = host_err; rd = host_rdata; break; end
      @(posedge clk); #1;
    end
  endtask

  task automatic xfer(input logic wr, input logic [31:0] d,
                      output logic acked, output logic err, output logic [31:0] rd);
    kick(wr, d);
    wait_ack(acked, err, rd);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, rd, base;
    logic a, e;
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset value and live enable bits
    rd_reg(2'd0, v); chk("R1 reset ctrl", v, 32'h4300_0002);
    dbgen = 1; rd_reg(2'd0, v); chk("R1 dev bit", v, 32'h4300_0042);
    spniden = 1; rd_reg(2'd0, v); chk("R1 sdev bit", v, 32'h4380_0042);

    // R2/R3: reserved bits and reserved encodings
    wr_reg(2'd0, 32'hFFFF_FFFF); rd_reg(2'd0, v); chk("R2 R3 all ones", v, 32'h4F83_0042);
    wr_reg(2'd0, 32'h0); rd_reg(2'd0, v); chk("R2 zeros", v, 32'h0080_0040);
    wr_reg(2'd0, 32'h0000_0023); rd_reg(2'd0, v); chk("R3 reserved codes", v, 32'h0080_0040);
    wr_reg(2'd0, 32'h0000_0011); rd_reg(2'd0, v); chk("R3 legal codes", v, 32'h0080_0051);
    wr_reg(2'd0, 32'h0000_0037); rd_reg(2'd0, v); chk("R3 reserved kept", v, 32'h0080_0051);
    wr_reg(2'd1, 32'h1234_5678); rd_reg(2'd1, v); chk("R2 addr readback", v, 32'h1234_5678);
    rd_reg(2'd3, v); chk("R2 select 3 zero", v, 32'h0);

    // R5: protection and security sweep
    for (int p = 0; p < 16; p++) begin
      for (int ns = 0; ns < 2; ns++) begin
        logic [3:0] pp;
        pp = 4'(p);
        wr_reg(2'd0, (32'(ns) << 30) | (32'(p) << 24) | 32'h2);
        @(negedge clk);
        chk("R5 prot", {25'h0, m_prot}, {25'h0, pp[3], 1'b0, pp[3], pp});
        chk("R5 nonsec", {31'h0, m_nonsec}, 32'(ns));
      end
    end

    // R6/R7/R8: sizes and lane offsets, reads and writes, with increment
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off += (1 << sz)) begin
        base = 32'h10 | 32'(off);
        wr_reg(2'd0, 32'h4000_0010 | 32'(sz));
        wr_reg(2'd1, base);
        xfer(0, 0, a, e, rd);
        chk("R7 read ack", {30'h0, a, e}, 32'h2);
        chk("R7 read lanes", rd, pattern(4'd4) & exp_mask(sz, off));
        chk("R6 size out", {29'h0, s_sz}, 32'(sz));
        rd_reg(2'd1, v); chk("R8 inc step", v, base + (32'h1 << sz));
        wr_reg(2'd1, base);
        xfer(1, 32'hC1D2_E3F4 ^ 32'(off), a, e, rd);
        chk("R6 write ack", {30'h0, a, e}, 32'h2);
        chk("R6 write lanes", cap_wdata, exp_place(32'hC1D2_E3F4 ^ 32'(off), sz, off));
      end
    end
    wr_reg(2'd0, 32'h4000_0002); wr_reg(2'd1, 32'h18);
    xfer(0, 0, a, e, rd); rd_reg(2'd1, v); chk("R8 no increment", v, 32'h18);

    // R4: authorisation gating
    n0 = ntrans;
    wr_reg(2'd0, 32'h0000_0002); spiden = 0;
    xfer(0, 0, a, e, rd); chk("R4 secure denied", {30'h0, a, e}, 32'h3);
    chk("R4 no transfer", 32'(ntrans), 32'(n0));
    @(posedge clk); #1; chk("R13 ack one cycle", {30'h0, host_ack, host_err}, 32'h0);
    spiden = 1; xfer(0, 0, a, e, rd); chk("R4 secure allowed", {30'h0, a, e}, 32'h2);
    wr_reg(2'd0, 32'h4000_0002); dbgen = 0; n0 = ntrans;
    xfer(0, 0, a, e, rd); chk("R4 dbgen low", {30'h0, a, e}, 32'h3);
    chk("R4 no transfer 2", 32'(ntrans), 32'(n0));
    dbgen = 1;

    // R9/R10/R8: error handling
    wr_reg(2'd0, 32'h4000_0012); wr_reg(2'd1, 32'h100);
    xfer(0, 0, a, e, rd); chk("R9 error reported", {30'h0, a, e}, 32'h3);
    rd_reg(2'd1, v); chk("R8 no inc on error", v, 32'h100);
    wr_reg(2'd1, 32'h10);
    xfer(0, 0, a, e, rd); chk("R9 continue without stop", {30'h0, a, e}, 32'h2);
    wr_reg(2'd0, 32'h4002_0012); wr_reg(2'd1, 32'h100);
    xfer(0, 0, a, e, rd); chk("R9 error with stop", {30'h0, a, e}, 32'h3);
    wr_reg(2'd1, 32'h10); n0 = ntrans;
    xfer(0, 0, a, e, rd); chk("R9 blocked", {30'h0, a, e}, 32'h3);
    chk("R9 blocked no transfer", 32'(ntrans), 32'(n0));
    wr_reg(2'd0, 32'h4002_0012);
    xfer(0, 0, a, e, rd); chk("R9 cleared by ctrl write", {30'h0, a, e}, 32'h2);
    wr_reg(2'd0, 32'h4001_0012); wr_reg(2'd1, 32'h104);
    xfer(0, 0, a, e, rd); chk("R10 error hidden", {30'h0, a, e}, 32'h2);

    // R11: busy window
    wr_reg(2'd0, 32'h4000_0012); wr_reg(2'd1, 32'h10); waits = 6;
    kick(0, 0);
    rd_reg(2'd0, v); chk("R11 busy bit", {31'h0, v[7]}, 32'h1);
    wr_reg(2'd1, 32'h44);
    host_sel = 2'd2; #0;
    wait_ack(a, e, rd); chk("R11 ack", {30'h0, a, e}, 32'h2);
    rd_reg(2'd1, v); chk("R11 addr write ignored", v, 32'h14);
    rd_reg(2'd0, v); chk("R11 busy clear", {31'h0, v[7]}, 32'h0);
    waits = 0;

    // R12: abort during stalled address phase
    stall_addr = 1; n0 = ntrans;
    kick(0, 0);
    @(negedge clk); chk("R12 address phase held", {31'h0, m_trans}, 32'h1);
    abort_req = 1;
    @(posedge clk); #1; abort_req = 0;
    chk("R12 abort ack", {30'h0, host_ack, host_err}, 32'h3);
    stall_addr = 0;
    @(negedge clk); chk("R12 dropped", {31'h0, m_trans}, 32'h0);
    chk("R12 no transfer", 32'(ntrans), 32'(n0));
    rd_reg(2'd1, v); chk("R12 addr kept", v, 32'h14);

    finished = 1;
    summary();
    $finish;
  end

endmodule